// File: doc/BRIEF.md
# CPU Doze Clock Divider

This block slows the processor core without touching the peripherals. A CPU clock enable rises on one cycle out of every 2^N, and a peripheral clock enable stays high on every cycle. Both enables come from the same system clock and the same cycle counter, so the core stays cycle-aligned with the peripherals and can reach their registers while it runs slowly. The block makes enables, not gated clocks, so downstream flops keep the system clock and qualify their updates with the enable.

Software sets the block up through one 16-bit control word on a simple write port, and reads the word back on a parallel output. The word holds an enable bit, a 3-bit power-of-two ratio and a wake-on-interrupt bit. When the wake bit is set, an interrupt request clears the enable in hardware. The core then returns to full speed, and software sees the cleared bit on the next readback.

Top module: `cpu_doze_divider`

## Requirements
- R1: After reset the control word reads 0x0000 (doze off, ratio code 0, wake bit clear), and cpu_en_o and periph_en_o are both high.
- R2: A write loads all 16 bits. Bit 15 is the wake-on-interrupt bit, bits 14:12 are the ratio code N, bit 11 is the doze enable, and bits 10:0 are plain storage with no effect. rd_data_o shows the written value from the cycle after the write edge.
- R3: With doze enabled and code N, cpu_en_o is high on one cycle in every 2^N. The first high cycle is the cycle right after the write that set the enable or the ratio. Code 0 gives high on every cycle and code 7 gives high once in 128 cycles.
- R4: With doze disabled, cpu_en_o is high on every cycle, whatever the ratio code.
- R5: periph_en_o is high on every cycle after reset.
- R6: A change of the enable bit or the ratio code restarts the divider phase. A write that keeps both the same (even when it changes bit 15 or bits 10:0) leaves the phase running.
- R7: When bit 15 and bit 11 are both set, an interrupt request sampled at an edge with no write clears bit 11 at that edge. cpu_en_o is then high from the next cycle on.
- R8: When bit 15 is clear, an interrupt request changes neither the control word nor the cpu_en_o pattern.
- R9: If a write and an interrupt request arrive at the same edge, the written value takes effect and the hardware clear does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word to write |
| irq_i | input | 1 | Interrupt request, sampled on each edge |
| rd_data_o | output | 16 | Control word readback |
| cpu_en_o | output | 1 | CPU clock enable |
| periph_en_o | output | 1 | Peripheral clock enable |

## Verification
The hardest cases to reach are the ones where timing overlaps. One is an interrupt on the same edge as a write. Another is rewriting the same ratio in the middle of a divider period, where the phase must carry on without a break. The bench drives these edges on purpose and checks outputs and readback on every cycle against a reference model built from the requirements. Separate runs also walk through the full 1:128 period and send interrupts with the wake bit clear, and with the wake bit set while doze is already off.

// File: rtl/doze_pkg.sv
package doze_pkg;
  localparam int REG_W   = 16;
  localparam int RATIO_W = 3;
  localparam int SPARE_W = REG_W - RATIO_W - 2;
  localparam int CNT_W   = (1 << RATIO_W) - 1;

  // Field order fixes the bit positions: wake bit 15, ratio 14:12, enable 11.
  typedef struct packed {
    logic               wake;
    logic [RATIO_W-1:0] ratio;
    logic               dozing;
    logic [SPARE_W-1:0] spare;
  } doze_ctrl_t;
endpackage

// File: rtl/doze_ctrl_reg.sv
module doze_ctrl_reg
  import doze_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en_i,
  input  doze_ctrl_t wr_word_i,
  input  logic       irq_i,
  output doze_ctrl_t ctrl_q_o,
  output doze_ctrl_t ctrl_d_o,
  output logic       restart_o
);
  doze_ctrl_t ctrl_q, ctrl_d;
  logic       hw_clear;

  assign hw_clear = irq_i && ctrl_q.wake && ctrl_q.dozing;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d = wr_word_i;
    end else if (hw_clear) begin
      ctrl_d.dozing = 1'b0;
    end
  end

  assign restart_o = (ctrl_d.dozing != ctrl_q.dozing) || (ctrl_d.ratio != ctrl_q.ratio);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign ctrl_q_o = ctrl_q;
  assign ctrl_d_o = ctrl_d;

  assert_irq_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_i && ctrl_q.wake && ctrl_q.dozing && !wr_en_i) |=> !ctrl_q.dozing);

  assert_irq_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_i && !ctrl_q.wake && !wr_en_i) |=> $stable(ctrl_q));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (ctrl_q == $past(wr_word_i)));
endmodule

// File: rtl/doze_rate_counter.sv
module doze_rate_counter
  import doze_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [RATIO_W-1:0] ratio_q_i,
  input  logic               dozing_d_i,
  output logic               cpu_en_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cpu_en_q;

  assign limit = ~({CNT_W{1'b1}} << ratio_q_i);

  always_comb begin
    if (restart_i)           cnt_d = '0;
    else if (cnt_q == limit) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      cpu_en_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      cpu_en_q <= !dozing_d_i || (cnt_d == '0);
    end
  end

  assign cpu_en_o = cpu_en_q;

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);

  assert_restart_phase_R6: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/cpu_doze_divider.sv
module cpu_doze_divider
  import doze_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cpu_en_o,
  output logic             periph_en_o
);
  doze_ctrl_t ctrl_q, ctrl_d;
  logic       restart;
  logic       periph_en_q;

  doze_ctrl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_word_i (doze_ctrl_t'(wr_data_i)),
    .irq_i     (irq_i),
    .ctrl_q_o  (ctrl_q),
    .ctrl_d_o  (ctrl_d),
    .restart_o (restart)
  );

  doze_rate_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .restart_i  (restart),
    .ratio_q_i  (ctrl_q.ratio),
    .dozing_d_i (ctrl_d.dozing),
    .cpu_en_o   (cpu_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) periph_en_q <= 1'b1;
    else     periph_en_q <= 1'b1;
  end

  assign periph_en_o = periph_en_q;
  assign rd_data_o   = ctrl_q;

  assert_full_speed_off_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.dozing |-> cpu_en_o);

  assert_periph_full_rate_R5: assert property (@(posedge clk) disable iff (rst)
    periph_en_o);

  assert_first_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (restart && ctrl_d.dozing) |=> cpu_en_o);
endmodule

// File: tb/cpu_doze_divider_tb_top.sv
module cpu_doze_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq = 1'b0;
  logic [15:0] rd_data;
  logic        cpu_en, periph_en;

  cpu_doze_divider dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_i(irq),
    .rd_data_o(rd_data), .cpu_en_o(cpu_en), .periph_en_o(periph_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  logic [17:0] exp_q[$];

  // reference model state
  logic [15:0] m_word = '0;
  int          m_cnt  = 0;

  function automatic logic [15:0] mk(bit wake, int ratio, bit en, logic [10:0] spare);
    return {wake, 3'(ratio), en, spare};
  endfunction

  function automatic logic [17:0] model_out();
    logic cpu;
    cpu = !m_word[11] || (m_cnt == 0);
    return {cpu, 1'b1, m_word};
  endfunction

  task automatic step();
    logic [15:0] nw;
    int lim;
    nw = m_word;
    if (wr_en) nw = wr_data;
    else if (irq && m_word[15] && m_word[11]) nw[11] = 1'b0;
    lim = (1 << m_word[14:12]) - 1;
    if (nw[11] != m_word[11] || nw[14:12] != m_word[14:12]) m_cnt = 0;
    else if (m_cnt == lim) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    m_word = nw;
    @(posedge clk); #1;
    exp_q.push_back(model_out());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(logic [15:0] v, bit with_irq = 1'b0);
    wr_en = 1'b1; wr_data = v; irq = with_irq;
    step();
    wr_en = 1'b0; irq = 1'b0;
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    step();
    irq = 1'b0;
  endtask

  // monitor: pops one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [17:0] e, a;
      e = exp_q.pop_front();
      a = {cpu_en, periph_en, rd_data};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got cpu_en=%b periph_en=%b rd=%h, expected cpu_en=%b periph_en=%b rd=%h",
                 cur_req, a[17], a[16], a[15:0], e[17], e[16], e[15:0]);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < WATCHDOG && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_q.push_back(model_out());
    cur_req = "R1"; idle(4);                               // reset state
    cur_req = "R5"; idle(2);                               // periph enable checked every cycle
    cur_req = "R3"; write(mk(0, 0, 1, 11'h000)); idle(5);  // 1:1
    cur_req = "R2"; write(mk(0, 2, 1, 11'h5A5)); idle(12); // 1:4, spare bits stored
    cur_req = "R3"; write(mk(0, 1, 1, 11'h000)); idle(7);  // 1:2
    cur_req = "R6"; idle(2); write(mk(1, 1, 1, 11'h7FF)); idle(6); // same ratio and enable, phase kept
    cur_req = "R6"; write(mk(1, 3, 1, 11'h7FF)); idle(3); write(mk(1, 3, 1, 11'h000)); idle(14);
    cur_req = "R6"; idle(2); write(mk(1, 2, 1, 11'h000)); idle(9); // ratio change restarts
    cur_req = "R4"; write(mk(0, 5, 0, 11'h000)); idle(10);
    cur_req = "R3"; write(mk(0, 7, 1, 11'h000)); idle(262);
    cur_req = "R8"; write(mk(0, 2, 1, 11'h000)); idle(1);
    pulse_irq(); idle(3); pulse_irq(); idle(6);
    cur_req = "R7"; write(mk(1, 2, 1, 11'h000)); idle(2);
    pulse_irq(); idle(6);
    cur_req = "R7"; pulse_irq(); idle(3);                  // wake set but doze already off
    cur_req = "R9"; write(mk(1, 3, 1, 11'h000)); idle(3);
    write(mk(1, 3, 1, 11'h001), 1'b1); idle(10);           // write and irq at the same edge
    cur_req = "R7"; pulse_irq(); idle(4);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule